// File: doc/BRIEF.md
# Per-Pin Configurable Interrupt Detector

This block watches a vector of already-synchronized general-purpose input pins and turns selected activity on each pin into a status bit. Every pin has its own trigger configuration, set by three control vectors. One bit chooses level or edge sensing. One bit asks for both edges. One polarity bit chooses the active level, or the single edge that counts. From these settings each pin runs in one of five modes: level-high, level-low, rising edge, falling edge or either edge.

Each pin keeps a raw status bit. For edge modes the bit is sticky and stays set until a clear strobe removes it. For level modes the bit tracks the pin, one register stage behind, and needs no clear. The raw status is recorded whatever the enable says. A per-pin enable gates the raw status to form the masked status, and all masked bits are ORed into a single interrupt line for a downstream controller. The register block that holds the configuration is a separate block; it drives the control vectors and a one-cycle clear strobe vector.

Top module: `gpio_irq_detect`

## Requirements
- R1: While reset is asserted and in the first cycle after it, rawStatus, maskedStatus and irqOut are all zero. The internal copy of the previous pin value resets to 0.
- R2: With senseLevel=1 and polarity=1 (level-high), rawStatus[i] after a rising clock edge equals the value pinIn[i] had at that edge.
- R3: With senseLevel=1 and polarity=0 (level-low), rawStatus[i] after a clock edge equals the inverse of pinIn[i] at that edge.
- R4: With senseLevel=0, bothEdges=0 and polarity=1 (rising), a 0-to-1 change of pinIn[i] between two clock edges sets rawStatus[i] at the second edge. The bit stays set when the pin returns to 0.
- R5: With senseLevel=0, bothEdges=0 and polarity=0 (falling), only a 1-to-0 change of pinIn[i] sets rawStatus[i]. A rise leaves the bit unchanged.
- R6: With senseLevel=0 and bothEdges=1, a change of pinIn[i] in either direction sets rawStatus[i], whatever the value of polarity[i].
- R7: maskedStatus equals rawStatus AND enable, bit by bit. irqOut is 1 exactly when any bit of maskedStatus is 1.
- R8: In edge mode, clearStb[i]=1 at a clock edge clears rawStatus[i] when no new edge arrives. clearStb[i]=0 leaves the bit unchanged.
- R9: When an edge event and clearStb[i]=1 fall in the same cycle, the event wins and rawStatus[i] stays 1.
- R10: In level mode clearStb[i] has no effect: rawStatus[i] still follows the pin.
- R11: rawStatus is recorded whether or not the pin is enabled. Setting enable[i] while rawStatus[i]=1 raises maskedStatus[i] and irqOut in the same cycle, without a clock edge.
- R12: Each pin behaves according to its own configuration, independent of what the other pins are doing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pinIn | input | NUM_PINS | Synchronized pin values |
| senseLevel | input | NUM_PINS | 1 = level sensing, 0 = edge sensing |
| bothEdges | input | NUM_PINS | 1 = either edge triggers (edge mode only) |
| polarity | input | NUM_PINS | Level: 1 high / 0 low; edge: 1 rising / 0 falling |
| enable | input | NUM_PINS | Per-pin interrupt enable |
| clearStb | input | NUM_PINS | One-cycle clear strobe for latched edge status |
| rawStatus | output | NUM_PINS | Per-pin status before masking |
| maskedStatus | output | NUM_PINS | rawStatus gated by enable |
| irqOut | output | 1 | OR of all maskedStatus bits |

## Verification
Two functions can meet in one cycle: a new edge on a pin and a clear strobe for that same pin. The bench forces this case directly by raising a rising-mode pin in the same cycle it pulses the clear bit. It expects the status bit to survive. The random phase also produces such collisions on its own, because clears are issued while pins toggle. A bench reference model, built from the requirements, then judges each cycle. A second overlap is also exercised: enable changes while status is pending. The bench checks the interrupt line between clock edges, after changing only the enable.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Per-pin strobes handed from trigger control to the status datapath.
  typedef struct packed {
    logic isLevel;   // pin runs in a level mode this cycle
    logic levelHit;  // pin sits at its active level
    logic edgeHit;   // qualifying transition seen this cycle
    logic clrHit;    // clear request for a latched edge bit
  } pinStrobe_t;

  typedef enum logic [2:0] {
    TRIG_LEVEL_HIGH = 3'd0,
    TRIG_LEVEL_LOW  = 3'd1,
    TRIG_RISE       = 3'd2,
    TRIG_FALL       = 3'd3,
    TRIG_BOTH       = 3'd4
  } trigMode_t;

  function automatic trigMode_t decodeMode(input logic sense, input logic both,
                                           input logic pol);
    trigMode_t m;
    if (sense)     m = pol ? TRIG_LEVEL_HIGH : TRIG_LEVEL_LOW;
    else if (both) m = TRIG_BOTH;
    else           m = pol ? TRIG_RISE : TRIG_FALL;
    return m;
  endfunction

endpackage

// File: rtl/irq_trig_ctrl.sv
module irq_trig_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [NUM_PINS-1:0]                pinIn,
  input  logic [NUM_PINS-1:0]                senseLevel,
  input  logic [NUM_PINS-1:0]                bothEdges,
  input  logic [NUM_PINS-1:0]                polarity,
  input  logic [NUM_PINS-1:0]                clearStb,
  output pinStrobe_t [NUM_PINS-1:0]          strobes
);

  logic [NUM_PINS-1:0] prevPin;

  // One-cycle delayed copy of the pins for transition detection.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevPin <= '0;
    else       prevPin <= pinIn;
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    trigMode_t mode;
    logic      roseNow;
    logic      fellNow;

    assign mode    = decodeMode(senseLevel[p], bothEdges[p], polarity[p]);
    assign roseNow = pinIn[p] & ~prevPin[p];
    assign fellNow = ~pinIn[p] & prevPin[p];

    always_comb begin
      strobes[p] = '0;
      unique case (mode)
        TRIG_LEVEL_HIGH: begin
          strobes[p].isLevel  = 1'b1;
          strobes[p].levelHit = pinIn[p];
        end
        TRIG_LEVEL_LOW: begin
          strobes[p].isLevel  = 1'b1;
          strobes[p].levelHit = ~pinIn[p];
        end
        TRIG_RISE: begin
          strobes[p].edgeHit = roseNow;
          strobes[p].clrHit  = clearStb[p];
        end
        TRIG_FALL: begin
          strobes[p].edgeHit = fellNow;
          strobes[p].clrHit  = clearStb[p];
        end
        TRIG_BOTH: begin
          strobes[p].edgeHit = roseNow | fellNow;
          strobes[p].clrHit  = clearStb[p];
        end
        default: strobes[p] = '0;
      endcase
    end
  end

endmodule

// File: rtl/irq_status_path.sv
module irq_status_path
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  pinStrobe_t [NUM_PINS-1:0] strobes,
  input  logic [NUM_PINS-1:0]       enable,
  output logic [NUM_PINS-1:0]       rawStatus,
  output logic [NUM_PINS-1:0]       maskedStatus,
  output logic                      irqOut
);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_stat
    logic nextBit;

    // Level pins track the pin; edge pins latch, and a new event beats a clear.
    always_comb begin
      if (strobes[p].isLevel) nextBit = strobes[p].levelHit;
      else                    nextBit = strobes[p].edgeHit |
                                        (rawStatus[p] & ~strobes[p].clrHit);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) rawStatus[p] <= 1'b0;
      else       rawStatus[p] <= nextBit;
    end
  end

  assign maskedStatus = rawStatus & enable;
  assign irqOut       = |maskedStatus;

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [NUM_PINS-1:0] senseLevel,
  input  logic [NUM_PINS-1:0] bothEdges,
  input  logic [NUM_PINS-1:0] polarity,
  input  logic [NUM_PINS-1:0] enable,
  input  logic [NUM_PINS-1:0] clearStb,
  output logic [NUM_PINS-1:0] rawStatus,
  output logic [NUM_PINS-1:0] maskedStatus,
  output logic                irqOut
);

  pinStrobe_t [NUM_PINS-1:0] strobes;

  irq_trig_ctrl #(.NUM_PINS(NUM_PINS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .pinIn      (pinIn),
    .senseLevel (senseLevel),
    .bothEdges  (bothEdges),
    .polarity   (polarity),
    .clearStb   (clearStb),
    .strobes    (strobes)
  );

  irq_status_path #(.NUM_PINS(NUM_PINS)) u_stat (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .enable       (enable),
    .rawStatus    (rawStatus),
    .maskedStatus (maskedStatus),
    .irqOut       (irqOut)
  );

endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk #(
  parameter int NUM_PINS = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_PINS-1:0] pinIn,
  input logic [NUM_PINS-1:0] senseLevel,
  input logic [NUM_PINS-1:0] bothEdges,
  input logic [NUM_PINS-1:0] polarity,
  input logic [NUM_PINS-1:0] enable,
  input logic [NUM_PINS-1:0] clearStb,
  input logic [NUM_PINS-1:0] rawStatus,
  input logic [NUM_PINS-1:0] maskedStatus,
  input logic                irqOut
);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
    a_r2_level_high: assert property (@(posedge clk) disable iff (!rstN)
      (senseLevel[p] && polarity[p]) |=> (rawStatus[p] == $past(pinIn[p])));

    a_r3_level_low: assert property (@(posedge clk) disable iff (!rstN)
      (senseLevel[p] && !polarity[p]) |=> (rawStatus[p] == !$past(pinIn[p])));

    a_r8_edge_hold: assert property (@(posedge clk) disable iff (!rstN)
      (!senseLevel[p] && rawStatus[p] && !clearStb[p]) |=> rawStatus[p]);

    a_r11_enable_gate: assert property (@(posedge clk) disable iff (!rstN)
      (rawStatus[p] && enable[p]) |-> (maskedStatus[p] && irqOut));
  end

  a_r7_quiet_when_masked: assert property (@(posedge clk) disable iff (!rstN)
    ((rawStatus & enable) == '0) |-> !irqOut);

  a_r7_masked_subset: assert property (@(posedge clk) disable iff (!rstN)
    ((maskedStatus & ~rawStatus) == '0));

endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.NUM_PINS(NUM_PINS)) u_chk (.*);

// File: tb/gpio_irq_detect_tb.sv
module gpio_irq_detect_tb;

  localparam int N      = 8;
  localparam int PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN;
  logic [N-1:0] pinIn, senseLevel, bothEdges, polarity, enable, clearStb;
  logic [N-1:0] rawStatus, maskedStatus;
  logic         irqOut;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [N-1:0] mPrev, mRaw;

  always #(PERIOD/2) clk = ~clk;

  gpio_irq_detect #(.NUM_PINS(N)) u_dut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .senseLevel(senseLevel),
    .bothEdges(bothEdges), .polarity(polarity), .enable(enable),
    .clearStb(clearStb), .rawStatus(rawStatus), .maskedStatus(maskedStatus),
    .irqOut(irqOut)
  );

  // Reference next-state from the requirements (R2..R6, R8..R10).
  function automatic logic [N-1:0] refNext(input logic [N-1:0] pin, prev, raw,
      sense, both, pol, clr);
    logic [N-1:0] n;
    for (int i = 0; i < N; i++) begin
      logic ev;
      if (sense[i]) n[i] = pol[i] ? pin[i] : ~pin[i];
      else begin
        if (both[i])     ev = pin[i] ^ prev[i];
        else if (pol[i]) ev = pin[i] & ~prev[i];
        else             ev = ~pin[i] & prev[i];
        n[i] = ev | (raw[i] & ~clr[i]);
      end
    end
    return n;
  endfunction

  task automatic chk(input string tag, input logic [N-1:0] act, exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic checkOuts(input string tag);
    chk(tag, rawStatus, mRaw);
    chk("R7 masked", maskedStatus, mRaw & enable);
    chk("R7 irq", {{(N-1){1'b0}}, irqOut}, {{(N-1){1'b0}}, |(mRaw & enable)});
  endtask

  // Inputs are already set; advance one clock and compare.
  task automatic step(input string tag);
    logic [N-1:0] expRaw;
    expRaw = refNext(pinIn, mPrev, mRaw, senseLevel, bothEdges, polarity, clearStb);
    @(posedge clk);
    #(PERIOD/4);
    mPrev = pinIn;
    mRaw  = expRaw;
    checkOuts(tag);
    clearStb = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd12345;
    void'($urandom(seed));
    rstN = 1'b0; pinIn = '0; senseLevel = '0; bothEdges = '0; polarity = '0;
    enable = '1; clearStb = '0; mPrev = '0; mRaw = '0;
    repeat (3) @(posedge clk);
    #(PERIOD/4);
    chk("R1 reset raw", rawStatus, '0);
    chk("R1 reset irq", {{(N-1){1'b0}}, irqOut}, '0);
    rstN = 1'b1;
    @(posedge clk); #(PERIOD/4);
    checkOuts("R1 first cycle");

    // R2 level high on pin 0
    senseLevel[0] = 1; polarity[0] = 1;
    pinIn[0] = 1; step("R2 level high set");
    chk("R2 bit0", {{(N-1){1'b0}}, rawStatus[0]}, 8'd1);
    pinIn[0] = 0; step("R2 level high drop");

    // R3 level low on pin 1
    senseLevel[1] = 1; polarity[1] = 0;
    step("R3 level low active");
    chk("R3 bit1", {{(N-1){1'b0}}, rawStatus[1]}, 8'd1);
    pinIn[1] = 1; step("R3 level low drop");

    // R4 rising on pin 2, R8 clear
    polarity[2] = 1;
    pinIn[2] = 1; step("R4 rise set");
    pinIn[2] = 0; step("R4 rise holds");
    chk("R4 bit2 held", {{(N-1){1'b0}}, rawStatus[2]}, 8'd1);
    clearStb = 8'h00; step("R8 zero clear no effect");
    clearStb[2] = 1; step("R8 clear");
    chk("R8 bit2 cleared", {{(N-1){1'b0}}, rawStatus[2]}, 8'd0);

    // R5 falling on pin 3
    polarity[3] = 0;
    pinIn[3] = 1; step("R5 rise ignored");
    chk("R5 bit3 quiet", {{(N-1){1'b0}}, rawStatus[3]}, 8'd0);
    pinIn[3] = 0; step("R5 fall set");

    // R6 both edges on pin 4, polarity ignored
    bothEdges[4] = 1; polarity[4] = 0;
    pinIn[4] = 1; step("R6 both rise");
    chk("R6 bit4 rise", {{(N-1){1'b0}}, rawStatus[4]}, 8'd1);
    clearStb[4] = 1; step("R6 clear");
    pinIn[4] = 0; step("R6 both fall");

    // R9 collision: rising edge on pin 2 with clear in the same cycle
    clearStb[2] = 1; pinIn[2] = 1; step("R9 edge beats clear");
    chk("R9 bit2 kept", {{(N-1){1'b0}}, rawStatus[2]}, 8'd1);

    // R10 clear on level pin 0 has no effect
    pinIn[0] = 1; step("R10 level set");
    clearStb[0] = 1; step("R10 clear ignored");
    chk("R10 bit0 kept", {{(N-1){1'b0}}, rawStatus[0]}, 8'd1);

    // R11 status pending while disabled, then enable between edges
    enable = '0; pinIn[0] = 0; step("R11 disabled record");
    chk("R11 raw kept", {{(N-1){1'b0}}, rawStatus[2]}, 8'd1);
    enable[2] = 1; #1;
    chk("R11 irq immediate", {{(N-1){1'b0}}, irqOut}, 8'd1);
    chk("R11 masked immediate", maskedStatus, 8'h04);

    // R12 random mix of modes and pins
    for (int c = 0; c < 3000; c++) begin
      if ($urandom_range(0, 15) == 0) begin
        senseLevel = N'($urandom); bothEdges = N'($urandom);
        polarity = N'($urandom);
      end
      if ($urandom_range(0, 7) == 0) enable = N'($urandom);
      pinIn = pinIn ^ (N'($urandom) & N'($urandom));
      if ($urandom_range(0, 3) == 0) clearStb = N'($urandom);
      step("R12 random");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule